// File: doc/BRIEF.md
# Hibernation Controller with Seconds Counter and Wake Pin

The block keeps a seconds counter, two compare values, a preload value and a bank of retained data words. It also drives a power-enable output that switches off the rest of the chip while it sleeps. Software uses a word-addressed register port. A write to the control register turns the counter on, picks the wake sources and, in the same write, can request sleep. While asleep the block holds `pwr_en` low until either the counter reaches a compare value or the active-low wake pin falls. It raises `pwr_en` again one slow tick later and records which source woke it.

The counter, compare, preload and retained-data registers belong to the slow timekeeping domain. Here that domain is a tick enable derived from the system clock by a prescaler. After each write to one of them, a write-complete flag reads low for a fixed number of slow ticks, and further slow-domain writes in that window are dropped. The block sleeps with pin wake as its only source when the counter is off. In that case the slow tick is stopped for the whole sleep and restarts when the pin wakes the block.

The block has two resets. A system reset clears the registers only when the counter-enable bit and the pin-wake-enable bit are both clear. A cold power-on reset clears everything. For the first three clocks after the bus clock is enabled, and after any reset, the port reports not-ready and ignores accesses.

Top module: `hib_ctrl`

## Requirements
- R1: `req_ready` is low until `bus_clk_en` has been high at three consecutive rising clock edges, and it drops after any reset. A write or read presented while `req_ready` is low has no effect, and a read returns 0.
- R2: Writing 0x4F to the control register (offset 0x010) moves the block into sleep. `pwr_en` is low from the next cycle, and the block wakes when the running counter equals the compare value at offset 0x004 or the one at 0x008.
- R3: Writing 0x56 to the control register sleeps with pin wake only and the counter off. While asleep, `slow_clk_on` is low and the counter does not change. A falling edge on `wake_n` restarts the tick and wakes the block, and status bit 1 records it.
- R4: Writing 0x5F to the control register sleeps with both sources armed, and either source wakes the block. After the wake, the control register reads back the written value with bit 1 (sleep request) cleared and bit 31 (write complete) set.
- R5: After an accepted write to a slow-domain register (0x004, 0x008, 0x00C, or the data words), control bit 31 reads 0 for WRC_TICKS slow ticks. Slow-domain writes during that window are dropped.
- R6: With control bit 0 set, the counter (read at 0x000) increments once every SLOW_DIV clocks. A write to the preload register at 0x00C loads the counter with the written value.
- R7: When control bit 0 is set before sleep, the counter keeps counting while asleep.
- R8: The NDATA retained words at 0x030 upward, in steps of 4, keep their values through sleep and wake.
- R9: A system reset clears the registers only when control bits 0 (counter enable) and 4 (pin wake enable) are both 0. Otherwise it leaves every register unchanged.
- R10: A cold power-on reset clears all registers, so control reads 0x80000000 and `pwr_en` is high.
- R11: `pwr_en` goes high on the first slow tick after a wake event. The status register at 0x014 sets bit 0 for a compare wake and bit 1 for a pin wake, and a write of 1 to a status bit clears it.
- R12: A `wake_n` falling edge while asleep with control bit 4 clear does not wake the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | System reset, synchronous, active high, selective |
| por | input | 1 | Cold power-on reset, synchronous, active high |
| bus_clk_en | input | 1 | Register-port clock enable |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, same cycle as the request |
| req_ready | output | 1 | Port accepts accesses |
| wake_n | input | 1 | External wake pin, active low |
| pwr_en | output | 1 | Power enable for the rest of the chip |
| slow_clk_on | output | 1 | Slow timekeeping tick is running |

## Verification
Assertions check the following on every cycle:
- the slow tick is absent during a gated sleep;
- the counter steps by one per enabled tick;
- `pwr_en` returns after the tick that follows a wake;
- compare values hold while the write-complete flag is low, and the control register holds while the port is not ready;
- compare values survive a system reset that is meant to be ignored.

Only the bench scenarios can show the rest:
- which wake source ends each of the three sleep codes;
- that retained words survive a full sleep;
- that the selective reset clears or keeps state depending on the enables.

These scenarios run against a behavioural model that is compared on every clock.

// File: rtl/hib_pkg.sv
package hib_pkg;
    localparam int REG_W = 32;
    localparam int AW    = 10;

    localparam logic [AW-1:0] OFF_CNT  = 10'h000;
    localparam logic [AW-1:0] OFF_M0   = 10'h004;
    localparam logic [AW-1:0] OFF_M1   = 10'h008;
    localparam logic [AW-1:0] OFF_LD   = 10'h00C;
    localparam logic [AW-1:0] OFF_CTRL = 10'h010;
    localparam logic [AW-1:0] OFF_STAT = 10'h014;
    localparam logic [AW-1:0] OFF_DATA = 10'h030;

    localparam int WRC_BIT = 31;

    typedef enum logic [1:0] {ST_RUN, ST_HIB, ST_WAKE} hib_state_e;

    // control register bits 6..0
    typedef struct packed {
        logic spare6;
        logic spare5;
        logic pin_wake;
        logic rtc_wake;
        logic spare2;
        logic hib;
        logic rtc_en;
    } hib_ctrl_t;

    function automatic logic any_wake_src(input logic [6:0] v);
        return v[3] | v[4];
    endfunction
endpackage

// File: rtl/hib_acc_gate.sv
module hib_acc_gate #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic ready
);
    localparam int CW = $clog2(DELAY + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) cnt <= '0;
        else if (cnt != CW'(DELAY)) cnt <= cnt + 1'b1;
    end

    assign ready = en && (cnt == CW'(DELAY));
endmodule

// File: rtl/hib_tick_gen.sv
module hib_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int DW = $clog2(DIV + 1);
    logic [DW-1:0] div;
    logic last;

    assign last = (div == DW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || last) div <= '0;
        else div <= div + 1'b1;
    end

    assign tick = run && last;
endmodule

// File: rtl/hib_pin_sync.sv
module hib_pin_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= 3'b111;
        else sh <= {sh[1:0], pin_n};
    end

    assign fall = sh[2] && !sh[1];
endmodule

// File: rtl/hib_ctrl.sv
module hib_ctrl
    import hib_pkg::*;
#(
    parameter int NDATA     = 64,
    parameter int SLOW_DIV  = 4,
    parameter int WRC_TICKS = 2,
    parameter int ACC_DELAY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              bus_clk_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [REG_W-1:0]  req_wdata,
    output logic [REG_W-1:0]  rd_data,
    output logic              req_ready,
    input  logic              wake_n,
    output logic              pwr_en,
    output logic              slow_clk_on
);
    localparam int WRC_W  = $clog2(WRC_TICKS + 1);
    localparam int DIDX_W = $clog2(NDATA);
    localparam logic [AW-1:0] DATA_LAST = OFF_DATA + AW'(4 * (NDATA - 1));

    hib_ctrl_t        ctrl;
    hib_state_e       state;
    logic [REG_W-1:0] cnt, m0, m1, ld;
    logic [REG_W-1:0] data [NDATA];
    logic [1:0]       stat;
    logic [WRC_W-1:0] wrc_cnt;

    logic side_rst, slow_tick, pin_fall, run;
    logic wrc_ok, acc, wr, rd, in_data, slow_wr, clear_all;
    logic rtc_hit, pin_hit, start_hib;
    logic [AW-1:0]     doff;
    logic [DIDX_W-1:0] didx;

    assign side_rst = rst || por;

    hib_acc_gate #(.DELAY(ACC_DELAY)) u_gate (
        .clk(clk), .rst(side_rst), .en(bus_clk_en), .ready(req_ready));

    hib_tick_gen #(.DIV(SLOW_DIV)) u_tick (
        .clk(clk), .rst(side_rst), .run(run), .tick(slow_tick));

    hib_pin_sync u_pin (
        .clk(clk), .rst(side_rst), .pin_n(wake_n), .fall(pin_fall));

    assign run         = !(state == ST_HIB && !ctrl.rtc_en);
    assign slow_clk_on = run;
    assign pwr_en      = (state == ST_RUN);

    assign wrc_ok  = (wrc_cnt == '0);
    assign acc     = req_valid && req_ready && !side_rst;
    assign wr      = acc && req_write;
    assign rd      = acc && !req_write;
    assign doff    = req_addr - OFF_DATA;
    assign didx    = doff[DIDX_W+1:2];
    assign in_data = (req_addr >= OFF_DATA) && (req_addr <= DATA_LAST) && (req_addr[1:0] == 2'b00);
    assign slow_wr = wr && wrc_ok &&
                     (req_addr == OFF_M0 || req_addr == OFF_M1 || req_addr == OFF_LD || in_data);

    assign clear_all = por || (rst && !ctrl.rtc_en && !ctrl.pin_wake);
    assign rtc_hit   = ctrl.rtc_en && ctrl.rtc_wake && (cnt == m0 || cnt == m1);
    assign pin_hit   = pin_fall && ctrl.pin_wake;
    assign start_hib = req_wdata[1] && any_wake_src(req_wdata[6:0]);

    always_ff @(posedge clk) begin
        if (clear_all) begin
            ctrl    <= '0;
            state   <= ST_RUN;
            cnt     <= '0;
            m0      <= '0;
            m1      <= '0;
            ld      <= '0;
            stat    <= '0;
            wrc_cnt <= '0;
            for (int i = 0; i < NDATA; i++) data[i] <= '0;
        end else begin
            if (wr && req_addr == OFF_STAT) stat <= stat & ~req_wdata[1:0];

            unique case (state)
                ST_RUN: begin
                    if (wr && req_addr == OFF_CTRL) begin
                        ctrl     <= hib_ctrl_t'(req_wdata[6:0]);
                        ctrl.hib <= start_hib;
                        if (start_hib) state <= ST_HIB;
                    end
                end
                ST_HIB: begin
                    if (rtc_hit || pin_hit) begin
                        state <= ST_WAKE;
                        stat  <= stat | {pin_hit, rtc_hit};
                    end
                end
                default: begin
                    if (slow_tick) begin
                        state    <= ST_RUN;
                        ctrl.hib <= 1'b0;
                    end
                end
            endcase

            if (slow_wr && req_addr == OFF_LD) begin
                ld  <= req_wdata;
                cnt <= req_wdata;
            end else if (slow_tick && ctrl.rtc_en) begin
                cnt <= cnt + 1'b1;
            end
            if (slow_wr && req_addr == OFF_M0) m0 <= req_wdata;
            if (slow_wr && req_addr == OFF_M1) m1 <= req_wdata;
            if (slow_wr && in_data) data[didx] <= req_wdata;

            if (slow_wr) wrc_cnt <= WRC_W'(WRC_TICKS);
            else if (slow_tick && !wrc_ok) wrc_cnt <= wrc_cnt - 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd) begin
            if (req_addr == OFF_CNT)       rd_data = cnt;
            else if (req_addr == OFF_M0)   rd_data = m0;
            else if (req_addr == OFF_M1)   rd_data = m1;
            else if (req_addr == OFF_LD)   rd_data = ld;
            else if (req_addr == OFF_CTRL) begin
                rd_data[6:0]   = ctrl;
                rd_data[WRC_BIT] = wrc_ok;
            end
            else if (req_addr == OFF_STAT) rd_data[1:0] = stat;
            else if (in_data)              rd_data = data[didx];
        end
    end

    // R1: control register untouched while the port is not ready
    a_r1_gate_ctrl: assert property (@(posedge clk) disable iff (rst || por)
        (req_valid && req_write && !req_ready && req_addr == OFF_CTRL) |=> $stable(ctrl));

    // R5: compare value holds while write-complete is low
    a_r5_wrc_drop: assert property (@(posedge clk) disable iff (rst || por)
        (req_valid && req_write && req_addr == OFF_M0 && !wrc_ok) |=> $stable(m0));

    // R3: no slow tick during a gated sleep
    a_r3_gated_no_tick: assert property (@(posedge clk) disable iff (rst || por)
        (state == ST_HIB && !ctrl.rtc_en) |-> !slow_tick);

    // R6: one step per enabled tick
    a_r6_count_step: assert property (@(posedge clk) disable iff (rst || por)
        (slow_tick && ctrl.rtc_en && !(slow_wr && req_addr == OFF_LD)) |=> (cnt == $past(cnt) + 1'b1));

    // R11: power returns after the tick following a wake
    a_r11_restore: assert property (@(posedge clk) disable iff (rst || por)
        (state == ST_WAKE && slow_tick) |=> pwr_en);

    // R9: ignored system reset keeps compare values
    a_r9_keep: assert property (@(posedge clk) disable iff (por)
        (rst && (ctrl.rtc_en || ctrl.pin_wake)) |=> ($stable(m0) && $stable(m1)));
endmodule

// File: tb/tb_hib_ctrl.sv
module tb_hib_ctrl;
    localparam int DIV  = 4;
    localparam int WRCT = 2;
    localparam int ACCD = 3;
    localparam int ND   = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b0, por = 1'b1, bus_en = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        req_ready, wake_n = 1'b1, pwr_en, slow_clk_on;

    int errs = 0, checks = 0, cyc = 0;
    bit chk_on = 0;

    always #4 clk = ~clk;

    hib_ctrl #(.NDATA(ND), .SLOW_DIV(DIV), .WRC_TICKS(WRCT), .ACC_DELAY(ACCD)) dut (
        .clk(clk), .rst(rst), .por(por), .bus_clk_en(bus_en),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .req_ready(req_ready),
        .wake_n(wake_n), .pwr_en(pwr_en), .slow_clk_on(slow_clk_on));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_acc, m_div, m_state, m_wrc;
    logic [1:0]  m_stat;
    logic [31:0] m_cnt, m_m0, m_m1, m_ld;
    logic [31:0] m_data [ND];
    logic [6:0]  m_ctrl;
    logic [2:0]  m_sh;

    function automatic bit is_data(input logic [9:0] a);
        return a >= 10'h030 && a <= 10'h12C && a[1:0] == 2'b00;
    endfunction

    function automatic bit model_run();
        return !(m_state == 1 && !m_ctrl[0]);
    endfunction

    function automatic logic [31:0] exp_rd();
        if (!(req_valid && !req_write && bus_en && m_acc == ACCD && !rst && !por)) return 0;
        case (req_addr)
            10'h000: return m_cnt;
            10'h004: return m_m0;
            10'h008: return m_m1;
            10'h00C: return m_ld;
            10'h010: return {(m_wrc == 0), 24'd0, m_ctrl};
            10'h014: return {30'd0, m_stat};
            default: return is_data(req_addr) ? m_data[(req_addr - 10'h030) >> 2] : 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit rdy, run, tick, fall, acc, wr, slowwr, clr, rhit, phit, hib, rtc_on;
        rdy    = bus_en && m_acc == ACCD;
        run    = model_run();
        tick   = run && m_div == DIV - 1;
        fall   = m_sh[2] && !m_sh[1];
        acc    = req_valid && rdy && !rst && !por;
        wr     = acc && req_write;
        slowwr = wr && m_wrc == 0 &&
                 (req_addr == 10'h004 || req_addr == 10'h008 || req_addr == 10'h00C || is_data(req_addr));
        if (rst || por) begin
            m_acc = 0; m_div = 0; m_sh = 3'b111;
        end else begin
            m_acc = !bus_en ? 0 : (m_acc < ACCD ? m_acc + 1 : m_acc);
            m_div = (!run || m_div == DIV - 1) ? 0 : m_div + 1;
            m_sh  = {m_sh[1:0], wake_n};
        end
        clr = por || (rst && !m_ctrl[0] && !m_ctrl[4]);
        if (clr) begin
            m_ctrl = 0; m_state = 0; m_cnt = 0; m_m0 = 0; m_m1 = 0; m_ld = 0;
            m_stat = 0; m_wrc = 0;
            for (int i = 0; i < ND; i++) m_data[i] = 0;
        end else begin
            rtc_on = m_ctrl[0];
            rhit = m_ctrl[0] && m_ctrl[3] && (m_cnt == m_m0 || m_cnt == m_m1);
            phit = fall && m_ctrl[4];
            if (wr && req_addr == 10'h014) m_stat = m_stat & ~req_wdata[1:0];
            if (m_state == 0) begin
                if (wr && req_addr == 10'h010) begin
                    hib = req_wdata[1] && (req_wdata[3] || req_wdata[4]);
                    m_ctrl = req_wdata[6:0];
                    m_ctrl[1] = hib;
                    if (hib) m_state = 1;
                end
            end else if (m_state == 1) begin
                if (rhit || phit) begin
                    m_state = 2;
                    m_stat = m_stat | {phit, rhit};
                end
            end else if (tick) begin
                m_state = 0;
                m_ctrl[1] = 1'b0;
            end
            if (slowwr && req_addr == 10'h00C) begin
                m_ld = req_wdata; m_cnt = req_wdata;
            end else if (tick && rtc_on) m_cnt = m_cnt + 1;
            if (slowwr && req_addr == 10'h004) m_m0 = req_wdata;
            if (slowwr && req_addr == 10'h008) m_m1 = req_wdata;
            if (slowwr && is_data(req_addr)) m_data[(req_addr - 10'h030) >> 2] = req_wdata;
            if (slowwr) m_wrc = WRCT;
            else if (tick && m_wrc > 0) m_wrc = m_wrc - 1;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            chk("R11 pwr_en per cycle", {31'd0, pwr_en}, {31'd0, (m_state == 0)});
            chk("R1 req_ready per cycle", {31'd0, req_ready}, {31'd0, (bus_en && m_acc == ACCD)});
            chk("R3 slow_clk_on per cycle", {31'd0, slow_clk_on}, {31'd0, model_run()});
            chk("R6 rd_data per cycle", rd_data, exp_rd());
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errs++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        step();
        while (!req_ready) step();
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        step();
        req_valid = 0; req_write = 0;
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
        step();
        while (!req_ready) step();
        req_valid = 1; req_write = 0; req_addr = a;
        #1 d = rd_data;
        step();
        req_valid = 0;
    endtask

    task automatic wait_wrc();
        logic [31:0] v;
        do bus_rd(10'h010, v); while (!v[31]);
    endtask

    task automatic wait_pwr(input int lim);
        for (int i = 0; i < lim && !pwr_en; i++) step();
    endtask

    task automatic pulse_pin();
        wake_n = 0;
        repeat (4) step();
        wake_n = 1;
    endtask

    initial begin
        logic [31:0] v, c1, c2, keep_m0;
        repeat (3) step();
        por = 0; chk_on = 1;
        chk("R10 pwr_en after cold reset", {31'd0, pwr_en}, 32'd1);
        chk("R1 not ready right after reset", {31'd0, req_ready}, 32'd0);
        bus_rd(10'h010, v);
        chk("R10 control after cold reset", v, 32'h8000_0000);

        // R1: port gating after clock enable
        step(); bus_en = 0;
        step(); bus_en = 1;
        req_valid = 1; req_write = 1; req_addr = 10'h004; req_wdata = 32'h55;
        chk("R1 ready low at enable", {31'd0, req_ready}, 32'd0);
        step(); req_valid = 0; req_write = 0;
        chk("R1 ready low after 1 edge", {31'd0, req_ready}, 32'd0);
        step();
        chk("R1 ready low after 2 edges", {31'd0, req_ready}, 32'd0);
        step();
        chk("R1 ready high after 3 edges", {31'd0, req_ready}, 32'd1);
        bus_rd(10'h004, v);
        chk("R1 early write dropped", v, 32'd0);

        // R5: write-complete window
        bus_wr(10'h004, 32'd7);
        bus_rd(10'h010, v);
        chk("R5 write-complete low after write", {31'd0, v[31]}, 32'd0);
        bus_wr(10'h004, 32'd9);
        wait_wrc();
        bus_rd(10'h004, v);
        chk("R5 write during window dropped", v, 32'd7);

        // R6: counting and load
        bus_wr(10'h00C, 32'd100);
        wait_wrc();
        bus_wr(10'h010, 32'h01);
        bus_rd(10'h000, c1);
        chk("R6 counter loaded and running", {31'd0, (c1 >= 32'd100 && c1 < 32'd110)}, 32'd1);
        repeat (38) step();
        bus_rd(10'h000, c2);
        chk("R6 ten ticks in forty clocks", c2 - c1, 32'd10);

        // R8 data words
        bus_wr(10'h030, 32'hA5A5_0001);
        wait_wrc();
        bus_wr(10'h12C, 32'h1234_5678);
        wait_wrc();

        // R2 / R7: compare wake
        bus_wr(10'h010, 32'h00);
        bus_wr(10'h00C, 32'd0);
        wait_wrc();
        bus_wr(10'h008, 32'd1000);
        wait_wrc();
        bus_wr(10'h004, 32'd5);
        wait_wrc();
        bus_wr(10'h010, 32'h4F);
        chk("R2 pwr_en low after 0x4F", {31'd0, pwr_en}, 32'd0);
        wait_pwr(400);
        chk("R2 woke by compare", {31'd0, pwr_en}, 32'd1);
        bus_rd(10'h000, v);
        chk("R7 counter ran while asleep", v, 32'd6);
        bus_rd(10'h014, v);
        chk("R11 status compare source", v, 32'd1);
        bus_wr(10'h014, 32'd1);
        bus_rd(10'h014, v);
        chk("R11 status cleared by write 1", v, 32'd0);

        // R12: pin ignored without pin wake
        bus_rd(10'h000, c1);
        bus_wr(10'h004, c1 + 32'd30);
        wait_wrc();
        bus_wr(10'h010, 32'h4F);
        repeat (4) step();
        pulse_pin();
        repeat (20) step();
        chk("R12 pin edge ignored", {31'd0, pwr_en}, 32'd0);
        wait_pwr(600);
        bus_rd(10'h014, v);
        chk("R12 compare was the source", v, 32'd1);
        bus_wr(10'h014, 32'd3);

        // R3: pin-only sleep with gated tick
        bus_wr(10'h010, 32'h56);
        chk("R3 tick gated while asleep", {31'd0, slow_clk_on}, 32'd0);
        chk("R3 pwr_en low", {31'd0, pwr_en}, 32'd0);
        bus_rd(10'h000, c1);
        repeat (20) step();
        bus_rd(10'h000, c2);
        chk("R3 counter frozen", c2, c1);
        pulse_pin();
        wait_pwr(100);
        chk("R3 woke by pin", {31'd0, pwr_en}, 32'd1);
        bus_rd(10'h014, v);
        chk("R3 status pin source", v, 32'd2);
        bus_wr(10'h014, 32'd2);

        // R4: either source
        bus_wr(10'h010, 32'h01);
        bus_rd(10'h000, c1);
        keep_m0 = c1 + 32'd100;
        bus_wr(10'h004, keep_m0);
        wait_wrc();
        bus_wr(10'h010, 32'h5F);
        chk("R4 pwr_en low after 0x5F", {31'd0, pwr_en}, 32'd0);
        repeat (10) step();
        pulse_pin();
        wait_pwr(100);
        bus_rd(10'h014, v);
        chk("R4 pin wakes 0x5F sleep", v, 32'd2);
        bus_rd(10'h010, v);
        chk("R4 control readback after wake", v, 32'h8000_005D);
        bus_rd(10'h030, v);
        chk("R8 first data word retained", v, 32'hA5A5_0001);
        bus_rd(10'h12C, v);
        chk("R8 last data word retained", v, 32'h1234_5678);

        // R9: selective system reset
        step(); rst = 1;
        step(); step(); rst = 0;
        bus_rd(10'h004, v);
        chk("R9 compare kept over reset", v, keep_m0);
        bus_rd(10'h030, v);
        chk("R9 data kept over reset", v, 32'hA5A5_0001);
        bus_wr(10'h010, 32'h00);
        step(); rst = 1;
        step(); rst = 0;
        bus_rd(10'h004, v);
        chk("R9 compare cleared when enables off", v, 32'd0);
        bus_rd(10'h030, v);
        chk("R9 data cleared when enables off", v, 32'd0);

        // R10: cold reset clears despite enables
        bus_wr(10'h010, 32'h11);
        bus_wr(10'h044, 32'h77);
        wait_wrc();
        step(); por = 1;
        step(); por = 0;
        bus_rd(10'h044, v);
        chk("R10 data cleared by cold reset", v, 32'd0);
        bus_rd(10'h010, v);
        chk("R10 control cleared by cold reset", v, 32'h8000_0000);

        repeat (4) step();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule